// File: doc/BRIEF.md
# Time-Shared Systolic FIR Multiply-Accumulate Chain

This block is the arithmetic core of a multi-channel FIR filter. A chain of `NTAP` taps is shared by `NCH` channels in strict rotation, with one channel slot entering per clock. Every tap holds its own circular line of `NCH` samples, one entry per slot. It also has a multiplier and an adder that adds its product to the registered partial sum of the tap before it. The sum leaves the last tap `NTAP` cycles after the slot entered.

With each slot the caller supplies a sample and a shift flag. When the flag is set, the sample becomes the newest history entry of that slot and every older entry moves one tap deeper. When the flag is clear, every tap writes back the entry it just read, so the slot's history is frozen while the other slots keep running. This lets channels with different input rates share one chain.

The flag travels down the chain one tap per cycle, in step with the data. The caller supplies coefficients already skewed to match the pipeline. A valid flag follows the same pipeline, so the output valid marks the sum that belongs to the same slot.

Top module: `tdm_fir_chain`

## Requirements
- R1: While reset is applied, and in the first cycle after it is released, `outSum` is zero and `outValid` is low. Reset clears the partial sums, the travelling shift flags and the valid pipeline.
- R2: `outValid` is high in the cycle that comes exactly `NTAP` clock edges after a cycle with `inValid` high, and low in every other cycle.
- R3: With `inShift` high, `inSample` becomes entry 0 (the newest) of the slot's history, entry k moves to entry k+1, and the oldest entry is dropped. `outSum` is the sum over taps i of coefficient i times history entry i.
- R4: With `inShift` low, the slot's history is left unchanged, and `outSum` is computed from the history held from the slot's previous turn.
- R5: Holding one slot does not change the history of any other slot.
- R6: The coefficient for tap i is taken from `coefIn[i*CW +: CW]` in the cycle that comes i cycles after the slot's input cycle.
- R7: Samples, coefficients and sums are two's complement signed. `outSum` is `DW+CW+clog2(NTAP)` bits wide and does not overflow, even when every operand is at full-scale negative.
- R8: The chain accepts a new slot on every clock cycle and never stalls.
- R9: Slots recur with period `NCH`: the input cycles t, t+NCH, t+2*NCH and so on operate on the same history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inSample | input | DW | Signed sample for the slot now entering |
| inShift | input | 1 | 1: push the sample into the slot's history; 0: hold the history |
| inValid | input | 1 | The sum for this slot is wanted at the output |
| coefIn | input | NTAP*CW | Signed coefficients, tap i at bits [i*CW +: CW], skewed by i cycles |
| outSum | output | DW+CW+clog2(NTAP) | Signed sum from the last tap |
| outValid | output | 1 | `outSum` belongs to a slot that entered with `inValid` high |

## Verification
The assertions assume that reset is applied before the first valid slot and that `NTAP` is at least 2. The partial-sum bound assumes nothing more than that the operands are in range for their widths. The sum checks rely on every history entry having been written, so the bench first drives `NCH*NTAP` cycles with the shift flag high and the valid flag low. The bench then drives coefficients with the pipeline skew from a schedule kept per slot. Only with that skew does the tap-by-tap sum match a history model kept per channel.

// File: rtl/tdm_fir_pkg.sv
package tdm_fir_pkg;

  // Strobes from control to one tap of the datapath
  typedef struct packed {
    logic shift;
  } tapStrobe_t;

  function automatic int accWidth(input int dw, input int cw, input int taps);
    return dw + cw + $clog2(taps);
  endfunction

endpackage

// File: rtl/tdm_fir_ctrl.sv
module tdm_fir_ctrl
  import tdm_fir_pkg::*;
#(
  parameter int NTAP = 8,
  localparam int CNTW = $clog2(NTAP + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inShift,
  input  logic       inValid,
  output tapStrobe_t strb [NTAP],
  output logic       outValid
);

  logic [NTAP-2:0] shfReg;
  logic [NTAP-1:0] vldPipe;
  logic [CNTW-1:0] sinceRst;

  // shift flag, one register per tap boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      shfReg <= '0;
    end else begin
      for (int i = NTAP - 2; i > 0; i--) shfReg[i] <= shfReg[i-1];
      shfReg[0] <= inShift;
    end
  end

  generate
    for (genvar i = 0; i < NTAP; i++) begin : g_strb
      if (i == 0) begin : g_head
        assign strb[i].shift = inShift;
      end else begin : g_body
        assign strb[i].shift = shfReg[i-1];
      end
    end
  endgenerate

  // valid flag follows the chain latency
  always_ff @(posedge clk) begin
    if (rst) begin
      vldPipe <= '0;
    end else begin
      for (int i = NTAP - 1; i > 0; i--) vldPipe[i] <= vldPipe[i-1];
      vldPipe[0] <= inValid;
    end
  end

  assign outValid = vldPipe[NTAP-1];

  // edges since reset release, saturating at the chain latency
  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != CNTW'(NTAP)) sinceRst <= sinceRst + 1'b1;
  end

  // R2
  early_valid_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (sinceRst == CNTW'(NTAP)));

endmodule

// File: rtl/tdm_fir_tap.sv
module tdm_fir_tap
  import tdm_fir_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int AW  = 35,
  parameter int IDX = 0,
  localparam int PW = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  tapStrobe_t           strb,
  input  logic signed [DW-1:0] dIn,
  input  logic signed [CW-1:0] coef,
  input  logic signed [AW-1:0] accIn,
  output logic signed [DW-1:0] dOut,
  output logic signed [AW-1:0] accOut
);

  logic signed [DW-1:0] line [NCH];
  logic signed [DW-1:0] oldest;
  logic signed [DW-1:0] keepVal;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] partial;

  assign oldest  = line[NCH-1];
  assign keepVal = strb.shift ? dIn : oldest;
  assign prod    = PW'(keepVal) * PW'(coef);
  assign partial = AW'(prod) + accIn;

  // circular per-slot history; data is not reset
  always_ff @(posedge clk) begin
    line[0] <= keepVal;
    for (int k = 1; k < NCH; k++) line[k] <= line[k-1];
    dOut <= oldest;
  end

  always_ff @(posedge clk) begin
    if (rst) accOut <= '0;
    else     accOut <= partial;
  end

  // R4
  hold_recirc_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.shift |=> (line[0] == $past(oldest)));

  // R3
  shift_load_chk: assert property (@(posedge clk) disable iff (rst)
    strb.shift |=> (line[0] == $past(dIn)));

  localparam logic signed [AW:0] ACC_LIM = (AW+1)'(IDX + 1) <<< (PW - 2);
  logic signed [AW:0] accWide;
  assign accWide = (AW+1)'(accOut);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (accWide <= ACC_LIM) && (accWide >= -ACC_LIM));

endmodule

// File: rtl/tdm_fir_dpath.sv
module tdm_fir_dpath
  import tdm_fir_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NTAP = 8,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int AW   = 35
) (
  input  logic                   clk,
  input  logic                   rst,
  input  tapStrobe_t             strb [NTAP],
  input  logic signed [DW-1:0]   sample,
  input  logic [NTAP*CW-1:0]     coefIn,
  output logic signed [AW-1:0]   outSum
);

  logic signed [DW-1:0] dLink   [NTAP];
  logic signed [AW-1:0] accLink [NTAP];
  logic signed [DW-1:0] tapDIn  [NTAP];
  logic signed [AW-1:0] tapAcc  [NTAP];

  generate
    for (genvar i = 0; i < NTAP; i++) begin : g_tap
      if (i == 0) begin : g_first
        assign tapDIn[i] = sample;
        assign tapAcc[i] = '0;
      end else begin : g_next
        assign tapDIn[i] = dLink[i-1];
        assign tapAcc[i] = accLink[i-1];
      end

      tdm_fir_tap #(
        .NCH(NCH), .DW(DW), .CW(CW), .AW(AW), .IDX(i)
      ) u_tap (
        .clk   (clk),
        .rst   (rst),
        .strb  (strb[i]),
        .dIn   (tapDIn[i]),
        .coef  ($signed(coefIn[i*CW +: CW])),
        .accIn (tapAcc[i]),
        .dOut  (dLink[i]),
        .accOut(accLink[i])
      );
    end
  endgenerate

  assign outSum = accLink[NTAP-1];

endmodule

// File: rtl/tdm_fir_chain.sv
module tdm_fir_chain
  import tdm_fir_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NTAP = 8,
  parameter int DW   = 16,
  parameter int CW   = 16,
  localparam int AW  = accWidth(DW, CW, NTAP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] inSample,
  input  logic                 inShift,
  input  logic                 inValid,
  input  logic [NTAP*CW-1:0]   coefIn,
  output logic signed [AW-1:0] outSum,
  output logic                 outValid
);

  tapStrobe_t strb [NTAP];

  tdm_fir_ctrl #(.NTAP(NTAP)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inShift (inShift),
    .inValid (inValid),
    .strb    (strb),
    .outValid(outValid)
  );

  tdm_fir_dpath #(
    .NCH(NCH), .NTAP(NTAP), .DW(DW), .CW(CW), .AW(AW)
  ) u_dpath (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .sample(inSample),
    .coefIn(coefIn),
    .outSum(outSum)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((outSum == '0) && !outValid));

endmodule

// File: tb/tdm_fir_chain_test.sv
module tdm_fir_chain_test;

  localparam int NCH  = 5;
  localparam int NTAP = 6;
  localparam int DW   = 12;
  localparam int CW   = 10;
  localparam int AW   = DW + CW + $clog2(NTAP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [DW-1:0] inSample = '0;
  logic inShift = 1'b0;
  logic inValid = 1'b0;
  logic [NTAP*CW-1:0] coefIn = '0;
  logic signed [AW-1:0] outSum;
  logic outValid;

  always #5 clk = ~clk;

  tdm_fir_chain #(.NCH(NCH), .NTAP(NTAP), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .inSample(inSample), .inShift(inShift),
    .inValid(inValid), .coefIn(coefIn), .outSum(outSum), .outValid(outValid)
  );

  int total = 0;
  int bad = 0;
  int slotNo = 0;
  longint hist [NCH][NTAP];
  bit     expV [$];
  longint expS [$];
  string  expT [$];
  int     modeOf [$];

  function automatic int coefFor(input int tap, input int slot, input int mode);
    if (mode == 1) return -(1 << (CW - 1));
    if (mode == 2) return (1 << (CW - 1)) - 1;
    return ((slot * 7 + tap * 13 + 3) % 61) - 30;
  endfunction

  function automatic int sampleFor(input int k);
    return ((k * 37 + 11) % 4001) - 2000;
  endfunction

  task automatic step(input int smp, input bit shf, input bit vld,
                      input int mode, input string tag);
    bit ev;
    longint es;
    string et;
    longint acc;
    int ch;
    // compare outputs for the slot that entered NTAP cycles ago
    ev = expV.pop_front();
    es = expS.pop_front();
    et = expT.pop_front();
    total++;
    if (outValid !== ev) begin
      bad++;
      $display("FAIL %s slot-valid: got %0b expected %0b", et, outValid, ev);
    end
    if (ev) begin
      total++;
      if (longint'($signed(outSum)) != es) begin
        bad++;
        $display("FAIL %s sum: got %0d expected %0d", et, longint'($signed(outSum)), es);
      end
    end
    // drive this slot
    modeOf.push_back(mode);
    inSample = DW'(smp);
    inShift  = shf;
    inValid  = vld;
    for (int i = 0; i < NTAP; i++) begin
      automatic int s = slotNo - i;
      coefIn[i*CW +: CW] = (s < 0) ? '0 : CW'(coefFor(i, s, modeOf[s]));
    end
    // reference model
    ch = slotNo % NCH;
    if (shf) begin
      for (int j = NTAP - 1; j > 0; j--) hist[ch][j] = hist[ch][j-1];
      hist[ch][0] = smp;
    end
    acc = 0;
    for (int j = 0; j < NTAP; j++) acc += hist[ch][j] * coefFor(j, slotNo, mode);
    expV.push_back(vld);
    expS.push_back(acc);
    expT.push_back(tag);
    slotNo++;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++)
      for (int j = 0; j < NTAP; j++) hist[c][j] = 0;

    // R1: outputs cleared while in reset
    repeat (3) begin
      @(negedge clk);
      total++;
      if (outValid !== 1'b0 || outSum !== '0) begin
        bad++;
        $display("FAIL R1 reset: got valid=%0b sum=%0d expected valid=0 sum=0",
                 outValid, outSum);
      end
    end
    rst = 1'b0;
    for (int k = 0; k < NTAP; k++) begin
      expV.push_back(1'b0);
      expS.push_back(0);
      expT.push_back("R1 R2");
    end

    // flush every history with known samples, no output wanted
    for (int k = 0; k < NCH * NTAP; k++) step(sampleFor(slotNo), 1'b1, 1'b0, 0, "R2");

    // full-rate shifting with coefficients varying per slot
    for (int k = 0; k < 3 * NCH * NTAP; k++)
      step(sampleFor(slotNo), 1'b1, 1'b1, 0, "R3 R6 R8 R9");

    // one slot held, the others keep shifting
    for (int k = 0; k < 4 * NCH; k++)
      step(sampleFor(slotNo), (slotNo % NCH) != 2, 1'b1, 0, "R4 R5 R9");

    // sparse valid and shift patterns
    for (int k = 0; k < 6 * NCH; k++)
      step(sampleFor(slotNo), (k % 2) == 0, (k % 3) != 0, 0, "R2 R3");

    // every slot held for two rounds
    for (int k = 0; k < 2 * NCH; k++) step(sampleFor(slotNo), 1'b0, 1'b1, 0, "R4");

    // full-scale operands
    for (int k = 0; k < NCH * NTAP; k++)
      step(-(1 << (DW - 1)), 1'b1, 1'b1, 1, "R7");
    for (int k = 0; k < NCH * NTAP; k++)
      step((1 << (DW - 1)) - 1, 1'b1, 1'b1, 1, "R7");
    for (int k = 0; k < NCH * NTAP; k++)
      step(-(1 << (DW - 1)), 1'b1, 1'b1, 2, "R7");

    // drain
    for (int k = 0; k < NTAP + 1; k++) step(0, 1'b0, 1'b0, 0, "R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule